// File: doc/BRIEF.md
# Character Display Power-Up Sequencer

This block runs on the host side of a character display module and brings the display controller from a cold start to a usable state. After reset it waits for the panel supply to settle. It then sends a fixed list of configuration commands over a request/done bus-cycle interface and waits a fixed time after each one. The controller cannot report busy during the first steps, so every wait is timed and none is polled. When the last wait has elapsed, the block raises a ready flag and stays idle until the next reset.

The bus can run one byte per transfer or one nibble per transfer. In nibble mode the block starts with a single nibble that switches the controller to the narrow bus. Every later byte then goes out as two transfers, upper half first, on bits 7..4 of the data output. The panel settings are static inputs: line count, font height, display on, cursor on, blink on, address increment and display scroll. They must be held stable from reset until ready.

Each wait is a cycle count derived from a clock-rate parameter (`CLK_MHZ`) and a time in microseconds. `PWR_SHIFT` shortens only the power-up wait, by right-shifting its cycle count. Every derived count must be at least 1.

The states are:
- `S_POWER`: power-up wait.
- `S_SEND_HI`: full byte, upper nibble or lone nibble on the bus.
- `S_SEND_LO`: lower nibble on the bus.
- `S_SETTLE`: execution wait after a command.
- `S_READY`: done.

The transitions are:
- POWER→SEND_HI when the timer expires.
- SEND_HI→SEND_LO on done for a split byte.
- SEND_HI→SETTLE on done for a byte or a lone nibble.
- SEND_LO→SETTLE on done.
- SETTLE→SEND_HI when the timer expires and steps remain; the step index advances.
- SETTLE→READY when the timer expires after the last step.
- Any state→POWER on reset.

Top module: `lcd_boot_seq`

## Requirements
- R1: During reset, and after reset is released, `bus_valid` and `init_ready` are low. The first request appears after exactly PWR_CYC = (T_PWR_US·CLK_MHZ)>>PWR_SHIFT clock edges following release.
- R2: Every request drives `bus_rs`=0 and `bus_rw`=0.
- R3: A request holds `bus_valid` and `bus_data` stable until the cycle in which `bus_done` is high. A `bus_done` pulse while no request is pending has no effect on timing or order.
- R4: In byte mode (`cfg_bus4`=0), five bytes are sent on `bus_data[7:0]`, in this order:
  - {0011, N, F, 00}
  - the same byte again
  - {00001, D, C, B}
  - 0x01
  - {000001, I, S}
  
  Here N=`cfg_two_line`, F=`cfg_font_tall`, D=`cfg_disp_on`, C=`cfg_cursor_on`, B=`cfg_blink_on`, I=`cfg_addr_inc`, S=`cfg_scroll`.
- R5: In nibble mode (`cfg_bus4`=1), the first transfer is the single nibble 0010. Each following byte is sent as its upper nibble and then its lower nibble, on `bus_data[7:4]`, with `bus_data[3:0]`=0. The function-set byte in this mode is {0010, N, F, 00}, and the low nibble is requested in the cycle after the high nibble's done.
- R6: After the done of the first step, requests stay low for exactly T_FS_US·CLK_MHZ cycles. After the clear command they stay low for T_CLR_US·CLK_MHZ cycles. After the second function set and after display control they stay low for T_CMD_US·CLK_MHZ cycles.
- R7: `init_ready` rises exactly T_CMD_US·CLK_MHZ cycles after the entry-mode command's final done. It then stays high with no further requests.
- R8: A reset asserted at any point restarts the whole sequence from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_bus4 | input | 1 | 1: nibble bus, 0: byte bus |
| cfg_two_line | input | 1 | Two display lines |
| cfg_font_tall | input | 1 | Tall character font |
| cfg_disp_on | input | 1 | Display enabled |
| cfg_cursor_on | input | 1 | Cursor shown |
| cfg_blink_on | input | 1 | Cursor blink |
| cfg_addr_inc | input | 1 | Address increments after a write |
| cfg_scroll | input | 1 | Display scrolls on write |
| bus_valid | output | 1 | Bus-cycle request |
| bus_done | input | 1 | Bus cycle complete (one cycle) |
| bus_data | output | 8 | Byte, or nibble on bits 7..4 |
| bus_rs | output | 1 | Register select (always 0) |
| bus_rw | output | 1 | Read/write (always 0 = write) |
| init_ready | output | 1 | Sequence complete |

## Verification
The first request is due at the sample after PWR_CYC active edges following reset release. Each next request or `init_ready` follows a done by exactly the settle count for that step, counting the state change and the timer load. The low nibble follows its high nibble's done with no idle cycle. The bench samples at falling edges and counts the cycles in which the awaited output is still low, then compares that count with the exact figure derived from the timing parameters. It does not merely check for a minimum. Data is captured in the first sample where the request is seen, and `bus_done` is raised only after a per-vector latency of one to three cycles.

// File: rtl/lcd_boot_pkg.sv
package lcd_boot_pkg;

    typedef enum logic [2:0] {
        S_POWER,
        S_SEND_HI,
        S_SEND_LO,
        S_SETTLE,
        S_READY
    } seq_state_t;

    typedef enum logic [2:0] {
        STEP_FSET_A,
        STEP_FSET_B,
        STEP_DISP,
        STEP_CLEAR,
        STEP_ENTRY
    } boot_step_t;

    typedef struct packed {
        logic two_line;
        logic font_tall;
        logic disp_on;
        logic cursor_on;
        logic blink_on;
        logic addr_inc;
        logic scroll;
    } panel_cfg_t;

    localparam logic [7:0] CLEAR_BYTE = 8'h01;

    // bit 4 selects bus width: 1 = byte bus, 0 = nibble bus
    function automatic logic [7:0] fset_byte(input logic bus4, input logic n, input logic f);
        return {3'b001, ~bus4, n, f, 2'b00};
    endfunction

    function automatic logic [7:0] disp_byte(input logic d, input logic c, input logic b);
        return {5'b00001, d, c, b};
    endfunction

    function automatic logic [7:0] entry_byte(input logic i, input logic s);
        return {6'b000001, i, s};
    endfunction

endpackage

// File: rtl/lcd_boot_timer.sv
module lcd_boot_timer #(
    parameter int unsigned CW      = 8,
    parameter int unsigned RST_VAL = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CW'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/lcd_boot_cmdgen.sv
module lcd_boot_cmdgen
    import lcd_boot_pkg::*;
#(
    parameter int unsigned CW      = 8,
    parameter int unsigned FS_CYC  = 1,
    parameter int unsigned CMD_CYC = 1,
    parameter int unsigned CLR_CYC = 1
) (
    input  boot_step_t    step,
    input  logic          bus4,
    input  panel_cfg_t    cfg,
    output logic [7:0]    cmd_byte,
    output logic          one_nibble,
    output logic          last_step,
    output logic [CW-1:0] settle_m1
);
    localparam logic [CW-1:0] FS_M1  = CW'(FS_CYC - 1);
    localparam logic [CW-1:0] CMD_M1 = CW'(CMD_CYC - 1);
    localparam logic [CW-1:0] CLR_M1 = CW'(CLR_CYC - 1);

    always_comb begin
        cmd_byte   = 8'h00;
        one_nibble = 1'b0;
        last_step  = 1'b0;
        settle_m1  = CMD_M1;
        unique case (step)
            STEP_FSET_A: begin
                // nibble bus: upper half of the narrow function set is the lone 0010 nibble
                cmd_byte   = fset_byte(bus4, cfg.two_line, cfg.font_tall);
                one_nibble = bus4;
                settle_m1  = FS_M1;
            end
            STEP_FSET_B: cmd_byte = fset_byte(bus4, cfg.two_line, cfg.font_tall);
            STEP_DISP:   cmd_byte = disp_byte(cfg.disp_on, cfg.cursor_on, cfg.blink_on);
            STEP_CLEAR: begin
                cmd_byte  = CLEAR_BYTE;
                settle_m1 = CLR_M1;
            end
            STEP_ENTRY: begin
                cmd_byte  = entry_byte(cfg.addr_inc, cfg.scroll);
                last_step = 1'b1;
            end
            default: last_step = 1'b1;
        endcase
    end
endmodule

// File: rtl/lcd_boot_seq.sv
module lcd_boot_seq
    import lcd_boot_pkg::*;
#(
    parameter int unsigned CLK_MHZ   = 50,
    parameter int unsigned T_PWR_US  = 40100,
    parameter int unsigned T_FS_US   = 40,
    parameter int unsigned T_CMD_US  = 38,
    parameter int unsigned T_CLR_US  = 1540,
    parameter int unsigned PWR_SHIFT = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_bus4,
    input  logic       cfg_two_line,
    input  logic       cfg_font_tall,
    input  logic       cfg_disp_on,
    input  logic       cfg_cursor_on,
    input  logic       cfg_blink_on,
    input  logic       cfg_addr_inc,
    input  logic       cfg_scroll,
    output logic       bus_valid,
    input  logic       bus_done,
    output logic [7:0] bus_data,
    output logic       bus_rs,
    output logic       bus_rw,
    output logic       init_ready
);
    localparam int unsigned PWR_CYC = (T_PWR_US * CLK_MHZ) >> PWR_SHIFT;
    localparam int unsigned FS_CYC  = T_FS_US * CLK_MHZ;
    localparam int unsigned CMD_CYC = T_CMD_US * CLK_MHZ;
    localparam int unsigned CLR_CYC = T_CLR_US * CLK_MHZ;
    localparam int unsigned MAX_A   = (PWR_CYC > CLR_CYC) ? PWR_CYC : CLR_CYC;
    localparam int unsigned MAX_B   = (FS_CYC > CMD_CYC) ? FS_CYC : CMD_CYC;
    localparam int unsigned MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CW      = $clog2(MAX_CYC + 1);

    seq_state_t    state_q, state_d;
    boot_step_t    step_q, step_d;
    panel_cfg_t    cfg;
    logic [7:0]    cmd_byte;
    logic          one_nibble;
    logic          last_step;
    logic [CW-1:0] settle_m1;
    logic          tmr_load;
    logic          tmr_expired;

    assign cfg = '{two_line:  cfg_two_line,  font_tall: cfg_font_tall,
                   disp_on:   cfg_disp_on,   cursor_on: cfg_cursor_on,
                   blink_on:  cfg_blink_on,  addr_inc:  cfg_addr_inc,
                   scroll:    cfg_scroll};

    lcd_boot_cmdgen #(
        .CW(CW), .FS_CYC(FS_CYC), .CMD_CYC(CMD_CYC), .CLR_CYC(CLR_CYC)
    ) u_cmdgen (
        .step       (step_q),
        .bus4       (cfg_bus4),
        .cfg        (cfg),
        .cmd_byte   (cmd_byte),
        .one_nibble (one_nibble),
        .last_step  (last_step),
        .settle_m1  (settle_m1)
    );

    lcd_boot_timer #(
        .CW(CW), .RST_VAL(PWR_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (settle_m1),
        .expired  (tmr_expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_POWER;
            step_q  <= STEP_FSET_A;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    // transitions
    always_comb begin
        state_d  = state_q;
        step_d   = step_q;
        tmr_load = 1'b0;
        unique case (state_q)
            S_POWER: begin
                if (tmr_expired) state_d = S_SEND_HI;
            end
            S_SEND_HI: begin
                if (bus_done) begin
                    if (cfg_bus4 && !one_nibble) begin
                        state_d = S_SEND_LO;
                    end else begin
                        state_d  = S_SETTLE;
                        tmr_load = 1'b1;
                    end
                end
            end
            S_SEND_LO: begin
                if (bus_done) begin
                    state_d  = S_SETTLE;
                    tmr_load = 1'b1;
                end
            end
            S_SETTLE: begin
                if (tmr_expired) begin
                    if (last_step) begin
                        state_d = S_READY;
                    end else begin
                        state_d = S_SEND_HI;
                        step_d  = boot_step_t'(step_q + 3'd1);
                    end
                end
            end
            S_READY: state_d = S_READY;
            default: state_d = S_POWER;
        endcase
    end

    // outputs
    always_comb begin
        bus_valid  = 1'b0;
        bus_data   = 8'h00;
        bus_rs     = 1'b0;
        bus_rw     = 1'b0;
        init_ready = 1'b0;
        unique case (state_q)
            S_SEND_HI: begin
                bus_valid = 1'b1;
                bus_data  = cfg_bus4 ? {cmd_byte[7:4], 4'h0} : cmd_byte;
            end
            S_SEND_LO: begin
                bus_valid = 1'b1;
                bus_data  = {cmd_byte[3:0], 4'h0};
            end
            S_READY:  init_ready = 1'b1;
            S_POWER, S_SETTLE: bus_valid = 1'b0;
            default:  bus_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/lcd_boot_chk.sv
module lcd_boot_chk #(
    parameter int unsigned PWR_CYC = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_bus4,
    input logic       bus_valid,
    input logic       bus_done,
    input logic [7:0] bus_data,
    input logic       bus_rs,
    input logic       bus_rw,
    input logic       init_ready
);
    logic [31:0] edges_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edges_q <= '0;
        else if (edges_q != 32'hFFFF_FFFF) edges_q <= edges_q + 1'b1;
    end

    // R1: outputs idle while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            a_reset_idle_r1: assert (!bus_valid && !init_ready)
                else $error("reset idle violated");
        end
    end

    // R1: no request before the power-up window has elapsed
    p_power_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (edges_q > PWR_CYC));

    p_write_instr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (!bus_rs && !bus_rw));

    p_hold_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_done) |=> (bus_valid && $stable(bus_data)));

    p_nibble_low_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && cfg_bus4) |-> (bus_data[3:0] == 4'h0));

    p_ready_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init_ready |=> init_ready);

    p_ready_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init_ready |-> !bus_valid);
endmodule

bind lcd_boot_seq lcd_boot_chk #(.PWR_CYC(PWR_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_bus4   (cfg_bus4),
    .bus_valid  (bus_valid),
    .bus_done   (bus_done),
    .bus_data   (bus_data),
    .bus_rs     (bus_rs),
    .bus_rw     (bus_rw),
    .init_ready (init_ready)
);

// File: tb/tb_lcd_boot_seq.sv
`timescale 1ns/1ps
module tb_lcd_boot_seq;
    localparam int CLK_MHZ   = 1;
    localparam int T_PWR_US  = 40100;
    localparam int T_FS_US   = 40;
    localparam int T_CMD_US  = 38;
    localparam int T_CLR_US  = 1540;
    localparam int PWR_SHIFT = 4;
    localparam int PWR_N = (T_PWR_US * CLK_MHZ) >> PWR_SHIFT;
    localparam int FS_N  = T_FS_US * CLK_MHZ;
    localparam int CMD_N = T_CMD_US * CLK_MHZ;
    localparam int CLR_N = T_CLR_US * CLK_MHZ;
    localparam int LIMIT = 5000;

    // {bus4, N, F, D, C, B, I, S, latency[1:0]}
    localparam logic [9:0] VEC [4] = '{
        10'b0_1_0_1_0_1_1_0_01,
        10'b1_1_1_1_1_0_0_1_10,
        10'b0_0_1_0_1_1_0_1_11,
        10'b1_0_0_1_1_1_1_1_01
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_bus4 = 0, cfg_two_line = 0, cfg_font_tall = 0, cfg_disp_on = 0;
    logic cfg_cursor_on = 0, cfg_blink_on = 0, cfg_addr_inc = 0, cfg_scroll = 0;
    logic bus_done = 1'b0;
    logic bus_valid, bus_rs, bus_rw, init_ready;
    logic [7:0] bus_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] exp_data [9];
    int exp_gap [9];
    int exp_n;

    always #5 clk = ~clk;

    lcd_boot_seq #(
        .CLK_MHZ(CLK_MHZ), .T_PWR_US(T_PWR_US), .T_FS_US(T_FS_US),
        .T_CMD_US(T_CMD_US), .T_CLR_US(T_CLR_US), .PWR_SHIFT(PWR_SHIFT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cfg_bus4(cfg_bus4), .cfg_two_line(cfg_two_line),
        .cfg_font_tall(cfg_font_tall), .cfg_disp_on(cfg_disp_on),
        .cfg_cursor_on(cfg_cursor_on), .cfg_blink_on(cfg_blink_on),
        .cfg_addr_inc(cfg_addr_inc), .cfg_scroll(cfg_scroll),
        .bus_valid(bus_valid), .bus_done(bus_done), .bus_data(bus_data),
        .bus_rs(bus_rs), .bus_rw(bus_rw), .init_ready(init_ready)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     req, what, act, act, expv, expv);
        end
    endtask

    // expected transfers derived from R4, R5, R6
    task automatic build_exp(input logic [9:0] v);
        logic [7:0] b [5];
        int g [5];
        b[0] = {3'b001, ~v[9], v[8], v[7], 2'b00};
        b[1] = b[0];
        b[2] = {5'b00001, v[6], v[5], v[4]};
        b[3] = 8'h01;
        b[4] = {6'b000001, v[3], v[2]};
        g[0] = PWR_N; g[1] = FS_N; g[2] = CMD_N; g[3] = CMD_N; g[4] = CLR_N;
        if (!v[9]) begin
            for (int i = 0; i < 5; i++) begin
                exp_data[i] = b[i];
                exp_gap[i]  = g[i];
            end
            exp_n = 5;
        end else begin
            exp_data[0] = 8'h20;
            exp_gap[0]  = PWR_N;
            for (int i = 1; i < 5; i++) begin
                exp_data[2*i-1] = {b[i][7:4], 4'h0};
                exp_gap[2*i-1]  = g[i];
                exp_data[2*i]   = {b[i][3:0], 4'h0};
                exp_gap[2*i]    = 0;
            end
            exp_n = 9;
        end
    endtask

    task automatic run_cfg(input logic [9:0] v, input int stop_after,
                           input bit inject, input string tag0);
        int lowcnt;
        int lat;
        build_exp(v);
        lat = (v[1:0] == 2'b00) ? 1 : int'(v[1:0]);
        @(negedge clk);
        rst_n = 1'b0;
        bus_done = 1'b0;
        {cfg_bus4, cfg_two_line, cfg_font_tall, cfg_disp_on,
         cfg_cursor_on, cfg_blink_on, cfg_addr_inc, cfg_scroll} = v[9:2];
        @(negedge clk);
        check(bus_valid == 1'b0, tag0, "request low in reset", int'(bus_valid), 0);
        check(init_ready == 1'b0, tag0, "ready low in reset", int'(init_ready), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < exp_n; k++) begin
            if (k == stop_after) return;
            lowcnt = 0;
            while (!bus_valid && lowcnt < LIMIT) begin
                lowcnt++;
                bus_done = (inject && k == 0 && lowcnt == 100);
                @(negedge clk);
            end
            bus_done = 1'b0;
            if (k == 0)
                check(lowcnt == exp_gap[k], inject ? "R3" : tag0, "power-up wait cycles", lowcnt, exp_gap[k]);
            else if (exp_gap[k] == 0)
                check(lowcnt == 0, "R5", "low nibble follows at once", lowcnt, 0);
            else
                check(lowcnt == exp_gap[k], "R6", "settle cycles before request", lowcnt, exp_gap[k]);
            check(bus_data == exp_data[k], v[9] ? "R5" : "R4", "transfer data",
                  int'(bus_data), int'(exp_data[k]));
            check(!bus_rs && !bus_rw, "R2", "rs/rw low", int'({bus_rs, bus_rw}), 0);
            repeat (lat - 1) @(negedge clk);
            check(bus_valid && bus_data == exp_data[k], "R3", "request held until done",
                  int'(bus_data), int'(exp_data[k]));
            bus_done = 1'b1;
            @(negedge clk);
            bus_done = 1'b0;
        end
        lowcnt = 0;
        while (!init_ready && lowcnt < LIMIT) begin
            lowcnt++;
            @(negedge clk);
        end
        check(lowcnt == CMD_N, "R7", "cycles from last done to ready", lowcnt, CMD_N);
        begin
            bit quiet;
            quiet = 1'b1;
            for (int i = 0; i < 10; i++) begin
                if (bus_valid || !init_ready) quiet = 1'b0;
                @(negedge clk);
            end
            check(quiet, "R7", "ready holds, no further request", int'(quiet), 1);
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) run_cfg(VEC[i], 99, 1'b0, "R1");
        // R8: abort in mid-sequence, then the full sequence must replay
        run_cfg(VEC[1], 4, 1'b0, "R1");
        run_cfg(VEC[1], 99, 1'b0, "R8");
        // R3: stray done during the power-up wait
        run_cfg(VEC[2], 99, 1'b1, "R1");
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule